// File: doc/BRIEF.md
# Phase-Switching Dual-Modulus Prescaler (15/16)

This block is a cycle-accurate digital model of a dual-modulus prescaler that divides by phase selection rather than by a synchronous counter. The fast input clock drives two 4-bit Johnson counters running side by side. Between them they provide eight square-wave phases with a period of eight input cycles, and neighbouring phases are one input cycle apart. An 8-to-1 selector picks one phase. A toggle stage divides the selected waveform by two to form the prescaler output. With the modulus control asserted, the selector moves once per output cycle to the phase that is one input cycle *ahead* of the current one. That move removes one input cycle from the output period. Because it can only drop a repeated sample, it never creates a short pulse.

At power-up the two counters can come up in either of two relative alignments. In the second alignment every odd-numbered phase is inverted. Shortly after reset the block works out which alignment is present by sampling phase 1 on the first rising edge of phase 0. It then orders its stepping to match, so that each step always goes to the leading neighbour in time.

Top module: `phase_switch_prescaler`

## Requirements
- R1: While `rst_n` is low, `pre_out` is 0 and `tap_sel` is 0. Both are sampled after at least one rising clock edge in reset.
- R2: In the standard alignment (`alt_seed`=0 during reset), each phase k in 1..3 equals phase 0 delayed by k input cycles. For k in 0..3, phase k+4 is the inverse of phase k. Phase 0 is a square wave with period 8.
- R3: In the alternate alignment (`alt_seed`=1 during reset), even-numbered phases follow R2 and every odd-numbered phase is the inverse of its R2 value.
- R4: No later than 12 cycles after reset release, `pattern_alt` equals 1 for the alternate alignment and 0 for the standard one. It then holds its value until the next reset.
- R5: When `mod_ctl` is 0 at the clock edge where `pre_out` rises, the next `pre_out` rising edge comes 16 input cycles later.
- R6: When `mod_ctl` is 1 at the clock edge where `pre_out` rises, the next `pre_out` rising edge comes 15 input cycles later.
- R7: `mod_ctl` is sampled only at the clock edge where `pre_out` rises. Its value on any other edge has no effect on the output period.
- R8: Each change of `tap_sel` moves it to the phase that leads the current one by one input cycle. In the standard alignment the leading-order ring is 0,1,2,3,4,5,6,7. In the alternate alignment it is 0,5,2,7,4,1,6,3, and the lead of an entry is the entry before it. At most one change occurs per output cycle.
- R9: Every high and every low interval of `pre_out` after its first edge lasts 7 or 8 input cycles, so no phase step produces a glitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_seed | input | 1 | Selects which of the two power-up alignments the counters take; sampled only during reset |
| mod_ctl | input | 1 | Modulus control: 1 selects divide-by-15, 0 selects divide-by-16 |
| phases | output | 8 | The eight generated phases, indexed by phase number |
| tap_sel | output | 3 | Index of the phase currently routed through the selector |
| pattern_alt | output | 1 | Detected alignment: 1 for the alternate pattern |
| pre_out | output | 1 | Prescaler output |

## Verification
The assertions assume that `alt_seed` is settled before reset is released and that `mod_ctl` is a synchronous input that may change on any cycle. They also assume that reset is held long enough for both counters to load their seeds. The stimulus changes `mod_ctl` and `alt_seed` only at falling clock edges. It keeps `alt_seed` fixed for the length of each run, and it applies reset for three cycles before every run. Random `mod_ctl` values, long runs of ones and zeros, and a value that toggles every cycle all stay inside these assumptions. At the same time they push the sample point into every position of the output cycle.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

  typedef int unsigned uint_t;

  // Physical tap index for a given time lag (in input cycles) behind phase 0.
  // In the alternate alignment, odd taps sit half a period away from their
  // standard position.
  function automatic uint_t tap_of_lag(uint_t lag, logic alt, uint_t nph);
    if (alt && (lag % 2 == 1))
      return (lag + nph / 2) % nph;
    return lag % nph;
  endfunction

  // Lag of the neighbour that leads a given lag by one input cycle.
  function automatic uint_t leading_lag(uint_t lag, uint_t nph);
    return (lag + nph - 1) % nph;
  endfunction

  // Output period in input cycles: two selector periods minus the steps taken.
  function automatic uint_t out_period(uint_t nph, uint_t steps);
    return 2 * nph - steps;
  endfunction

endpackage

// File: rtl/pscl_phase_gen.sv
module pscl_phase_gen #(
  parameter int NPH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alt_seed,
  output logic [NPH-1:0] ph
);
  localparam int JW = NPH / 2;
  // Predecessor of the all-zero Johnson state: the odd-group counter starts
  // one input cycle behind the even-group counter.
  localparam logic [JW-1:0] LAG_SEED = {1'b1, {(JW-1){1'b0}}};

  logic [JW-1:0] even_q;
  logic [JW-1:0] odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      even_q <= '0;
      odd_q  <= alt_seed ? ~LAG_SEED : LAG_SEED;
    end else begin
      even_q <= {even_q[JW-2:0], ~even_q[JW-1]};
      odd_q  <= {odd_q[JW-2:0],  ~odd_q[JW-1]};
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_tap
    if (i % 2 == 0) begin : g_even
      if (i < JW) begin : g_lo
        assign ph[i] = even_q[i];
      end else begin : g_hi
        assign ph[i] = ~even_q[i-JW];
      end
    end else begin : g_odd
      if (i < JW) begin : g_lo
        assign ph[i] = odd_q[i-1];
      end else begin : g_hi
        assign ph[i] = ~odd_q[i-1-JW];
      end
    end
  end

endmodule

// File: rtl/pscl_pattern_det.sv
module pscl_pattern_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_ref,
  input  logic ph_next,
  output logic pat_alt,
  output logic pat_vld
);
  logic ref_d;
  logic ref_rise;

  assign ref_rise = ph_ref & ~ref_d;

  // On the first rise of the reference phase, its neighbour is still low when
  // it trails by one cycle, and already high when it trails by five.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d   <= 1'b0;
      pat_alt <= 1'b0;
      pat_vld <= 1'b0;
    end else begin
      ref_d <= ph_ref;
      if (ref_rise && !pat_vld) begin
        pat_alt <= ph_next;
        pat_vld <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pscl_step_ctrl.sv
module pscl_step_ctrl
  import pscl_pkg::*;
#(
  parameter int NPH = 8,
  parameter int LW  = $clog2(NPH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] ph,
  input  logic           pat_alt,
  input  logic           pat_vld,
  input  logic           arm_evt,
  input  logic           mod_ctl,
  output logic [LW-1:0]  lag_q,
  output logic [LW-1:0]  tap,
  output logic           mux_lvl,
  output logic           step_fire
);
  logic [LW-1:0] lead_lag;
  logic [LW-1:0] lead_tap;
  logic          lead_lvl;
  logic          pend_q;
  logic          level_match;

  assign lead_lag    = LW'(leading_lag(uint_t'(lag_q), uint_t'(NPH)));
  assign tap         = LW'(tap_of_lag(uint_t'(lag_q), pat_alt, uint_t'(NPH)));
  assign lead_tap    = LW'(tap_of_lag(uint_t'(lead_lag), pat_alt, uint_t'(NPH)));
  assign mux_lvl     = ph[tap];
  assign lead_lvl    = ph[lead_tap];
  assign level_match = (mux_lvl == lead_lvl);
  assign step_fire   = pend_q & pat_vld & level_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (arm_evt)
        pend_q <= mod_ctl;
      else if (step_fire)
        pend_q <= 1'b0;
      if (step_fire)
        lag_q <= lead_lag;
    end
  end

endmodule

// File: rtl/pscl_out_div.sv
module pscl_out_div (
  input  logic clk,
  input  logic rst_n,
  input  logic mux_lvl,
  output logic arm_evt,
  output logic out_q
);
  logic mux_d;
  logic mux_rise;

  assign mux_rise = mux_lvl & ~mux_d;
  assign arm_evt  = mux_rise & ~out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_d <= 1'b0;
      out_q <= 1'b0;
    end else begin
      mux_d <= mux_lvl;
      out_q <= out_q ^ mux_rise;
    end
  end

endmodule

// File: rtl/phase_switch_prescaler.sv
module phase_switch_prescaler #(
  parameter int NPH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alt_seed,
  input  logic                    mod_ctl,
  output logic [NPH-1:0]          phases,
  output logic [$clog2(NPH)-1:0]  tap_sel,
  output logic                    pattern_alt,
  output logic                    pre_out
);
  localparam int LW = $clog2(NPH);

  logic [NPH-1:0] ph;
  logic           pat_alt_q;
  logic           pat_vld;
  logic [LW-1:0]  lag_q;
  logic [LW-1:0]  tap;
  logic           mux_lvl;
  logic           step_fire;
  logic           arm_evt;
  logic           out_q;

  pscl_phase_gen #(.NPH(NPH)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt_seed (alt_seed),
    .ph       (ph)
  );

  pscl_pattern_det u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph_ref  (ph[0]),
    .ph_next (ph[1]),
    .pat_alt (pat_alt_q),
    .pat_vld (pat_vld)
  );

  pscl_step_ctrl #(.NPH(NPH), .LW(LW)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .pat_alt   (pat_alt_q),
    .pat_vld   (pat_vld),
    .arm_evt   (arm_evt),
    .mod_ctl   (mod_ctl),
    .lag_q     (lag_q),
    .tap       (tap),
    .mux_lvl   (mux_lvl),
    .step_fire (step_fire)
  );

  pscl_out_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .mux_lvl (mux_lvl),
    .arm_evt (arm_evt),
    .out_q   (out_q)
  );

  assign phases      = ph;
  assign tap_sel     = tap;
  assign pattern_alt = pat_alt_q;
  assign pre_out     = out_q;

endmodule

// File: rtl/pscl_checker.sv
module pscl_checker
  import pscl_pkg::*;
#(
  parameter int NPH = 8,
  parameter int LW  = $clog2(NPH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_ctl,
  input logic          pre_out,
  input logic          arm_evt,
  input logic          step_fire,
  input logic          mux_lvl,
  input logic [LW-1:0] lag_q,
  input logic          pat_alt,
  input logic          pat_vld
);
  localparam int CW = LW + 3;

  logic          pre_d;
  logic          pre_rise;
  logic [CW-1:0] per_cnt;
  logic          armed;
  logic          armed_prev;
  logic [1:0]    arms;
  logic [1:0]    step_cnt;

  assign pre_rise = pre_out & ~pre_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_d      <= 1'b0;
      per_cnt    <= '0;
      armed      <= 1'b0;
      armed_prev <= 1'b0;
      arms       <= '0;
      step_cnt   <= '0;
    end else begin
      pre_d   <= pre_out;
      per_cnt <= pre_rise ? CW'(1) : per_cnt + CW'(1);
      if (arm_evt) begin
        armed      <= mod_ctl;
        armed_prev <= armed;
        if (arms != 2'd2) arms <= arms + 2'd1;
        step_cnt   <= '0;
      end else if (step_fire && step_cnt != 2'd3) begin
        step_cnt <= step_cnt + 2'd1;
      end
    end
  end

  AST_LAG_TO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lag_q) |-> (lag_q == $past(lag_q) - LW'(1))); // R8

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= 2'd1); // R8

  AST_NO_RUNT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_lvl) |=> mux_lvl); // R9

  AST_NO_RUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mux_lvl) |=> !mux_lvl); // R9

  AST_PERIOD_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_rise && arms == 2'd2 && !armed_prev) |->
      (uint_t'(per_cnt) == out_period(uint_t'(NPH), 0))); // R5

  AST_PERIOD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_rise && arms == 2'd2 && armed_prev) |->
      (uint_t'(per_cnt) == out_period(uint_t'(NPH), 1))); // R6

  AST_STEP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> armed); // R7

  AST_PATTERN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pat_vld |=> (pat_vld && $stable(pat_alt))); // R4

endmodule

bind phase_switch_prescaler pscl_checker #(.NPH(NPH), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_ctl   (mod_ctl),
  .pre_out   (pre_out),
  .arm_evt   (arm_evt),
  .step_fire (step_fire),
  .mux_lvl   (mux_lvl),
  .lag_q     (lag_q),
  .pat_alt   (pat_alt_q),
  .pat_vld   (pat_vld)
);

// File: tb/tb_phase_switch_prescaler.sv
module tb_phase_switch_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alt_seed = 1'b0;
  logic       mod_ctl = 1'b0;
  logic [7:0] phases;
  logic [2:0] tap_sel;
  logic       pattern_alt;
  logic       pre_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  phase_switch_prescaler dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .alt_seed    (alt_seed),
    .mod_ctl     (mod_ctl),
    .phases      (phases),
    .tap_sel     (tap_sel),
    .pattern_alt (pattern_alt),
    .pre_out     (pre_out)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Leading neighbour taken from the time-order ring of each alignment.
  function automatic int lead_of(int tap, bit alt);
    int ring [8];
    if (alt) ring = '{0, 5, 2, 7, 4, 1, 6, 3};
    else     ring = '{0, 1, 2, 3, 4, 5, 6, 7};
    for (int i = 0; i < 8; i++)
      if (ring[i] == tap) return ring[(i + 7) % 8];
    return -1;
  endfunction

  // Expected phase vector from the history of phase 0 (hist[j] = phase 0, j cycles ago).
  function automatic logic [7:0] expect_phases(logic [7:0] hist, bit alt);
    logic [7:0] e;
    for (int k = 0; k < 8; k++) begin
      e[k] = (k < 4) ? hist[k] : ~hist[k-4];
      if (alt && (k % 2 == 1)) e[k] = ~e[k];
    end
    return e;
  endfunction

  // mode: 0 random, 1 held high, 2 held low, 3 toggling every cycle
  task automatic run(bit alt, int periods, int mode);
    logic [7:0] hist = '0;
    int  cyc = 0;
    int  rises = 0;
    int  last_rise = 0;
    int  last_edge = -1;
    bit  mc_at_rise = 1'b0;
    bit  prev_out = 1'b0;
    int  prev_tap = 0;
    string preq;

    @(negedge clk);
    rst_n    = 1'b0;
    alt_seed = alt;
    mod_ctl  = 1'b0;
    repeat (3) @(negedge clk);
    check(pre_out == 1'b0, "R1 pre_out in reset", int'(pre_out), 0);
    check(tap_sel == 3'd0, "R1 tap_sel in reset", int'(tap_sel), 0);
    rst_n = 1'b1;

    while (rises < periods) begin
      @(negedge clk);
      cyc++;
      hist = {hist[6:0], phases[0]};
      if (cyc > 8)
        check(phases == expect_phases(hist, alt), alt ? "R3 phase pattern" : "R2 phase pattern",
              int'(phases), int'(expect_phases(hist, alt)));
      if (cyc == 12)
        check(pattern_alt == alt, "R4 detected alignment", int'(pattern_alt), int'(alt));
      if (cyc > 12 && cyc % 50 == 0)
        check(pattern_alt == alt, "R4 alignment held", int'(pattern_alt), int'(alt));

      if (pre_out != prev_out) begin
        if (last_edge >= 0)
          check((cyc - last_edge) == 7 || (cyc - last_edge) == 8, "R9 half period",
                cyc - last_edge, 8);
        last_edge = cyc;
        if (pre_out) begin
          if (rises > 0) begin
            if (mode == 3)      preq = "R7 period";
            else if (mc_at_rise) preq = "R6 period";
            else                 preq = "R5 period";
            check((cyc - last_rise) == (mc_at_rise ? 15 : 16), preq,
                  cyc - last_rise, mc_at_rise ? 15 : 16);
          end
          mc_at_rise = mod_ctl;
          last_rise  = cyc;
          rises++;
        end
        prev_out = pre_out;
      end

      if (int'(tap_sel) != prev_tap) begin
        check(int'(tap_sel) == lead_of(prev_tap, alt), "R8 step to leading tap",
              int'(tap_sel), lead_of(prev_tap, alt));
        prev_tap = int'(tap_sel);
      end

      case (mode)
        0: mod_ctl = 1'($urandom_range(0, 1));
        1: mod_ctl = 1'b1;
        2: mod_ctl = 1'b0;
        default: mod_ctl = ~mod_ctl;
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    run(1'b0, 200, 0);
    run(1'b1, 200, 0);
    run(1'b0, 40, 1);
    run(1'b1, 40, 1);
    run(1'b0, 30, 2);
    run(1'b1, 30, 2);
    run(1'b0, 60, 3);
    run(1'b1, 60, 3);
    finish_up();
  end

endmodule